// File: doc/BRIEF.md
# Single-Word SDRAM Read Sequencer with Auto Precharge

This block fetches one data word from a synchronous DRAM per host request and leaves the bank closed afterwards. A request carries a bank, a row and a column. The host presents it on a valid/ready port. The sequencer opens the row, waits the minimum activate-to-read time, and issues a read with the auto-precharge flag set, so no separate precharge command is needed. It then collects the word that the memory returns two clocks later. The word comes back on a plain output with a one-cycle valid strobe. That return path has no back-pressure, so the host must take the word in the cycle it is flagged.

All memory timings are given in nanoseconds as parameters and converted to whole clocks by rounding up. The read is placed late enough that the precharge it triggers cannot cut the row's minimum open time short. The precharge is taken to start one clock after the read command. The next row opening is held off until the row-cycle minimum has passed, and also until the precharge recovery time after that internal precharge has passed. The request port follows valid/ready rules. A request is taken on a clock edge where both valid and ready are high. While valid is high and ready is low, the host must hold the request fields stable. Ready is high only when the sequencer is idle and the row-cycle spacing has elapsed.

The memory is read with burst length one and CAS latency two. The column width follows the data width: 8 bits at x16, 9 bits at x8 and 10 bits at x4.

Top module: `sdram_rdap_seq`

## Requirements
- R1: From reset, the command pins show NOP, the address and bank outputs are zero and rd_valid is low. sd_cke is high and sd_dqm is low in every cycle.
- R2: req_ready is high exactly when no access is in progress and at least NEXT_ACT-1 cycles have passed since the last ACTIVE cycle. A request is taken only on an edge where req_valid and req_ready are both high.
- R3: The cycle after a request is taken carries ACTIVE. sd_ba equals the request bank and sd_addr equals the request row.
- R4: READ appears RD_OFF cycles after ACTIVE, where RD_OFF = max(ceil(tRCD), ceil(tRAS) - 1). Only NOP is driven between ACTIVE and READ.
- R5: On READ, sd_addr[10] is 1 to select auto precharge. sd_addr holds the request column in its low COL_W bits, and every other address bit is 0. COL_W is 8 at data width 16, 9 at width 8 and 10 at width 4. sd_ba repeats the request bank.
- R6: The {cs_n, ras_n, cas_n, we_n} pins use these encodings: NOP = 0111, ACTIVE = 0011 and READ = 0101. No other value is driven.
- R7: sd_dq is sampled on the second clock edge after the edge that takes the READ. rd_valid is then high for exactly one cycle, three cycles after the READ cycle, with that word on rd_data.
- R8: Two ACTIVE cycles are at least NEXT_ACT = max(ceil(tRC), RD_OFF + 1 + ceil(tRP)) cycles apart. No ACTIVE is driven before the previous word has been delivered.
- R9: In every NOP cycle, sd_addr and sd_ba are zero.
- R10: While no request is being taken, changes on req_bank, req_row and req_col do not affect the access in flight or any later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the memory |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request this cycle |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 10 | Column of the request; bits at and above COL_W are ignored |
| rd_valid | output | 1 | One-cycle strobe for a returned word |
| rd_data | output | DATA_W | Returned word |
| sd_cke | output | 1 | Memory clock enable, always high |
| sd_cs_n | output | 1 | Memory chip select, active low |
| sd_ras_n | output | 1 | Memory row strobe, active low |
| sd_cas_n | output | 1 | Memory column strobe, active low |
| sd_we_n | output | 1 | Memory write enable, active low |
| sd_ba | output | 2 | Memory bank select |
| sd_addr | output | 12 | Memory address bus |
| sd_dqm | output | 1 | Data mask, always low |
| sd_dq | input | DATA_W | Read data from the memory |

## Verification
A wrong state register or a wrong count in the read-placement counter shows up within one access. READ moves away from its fixed offset after ACTIVE, or a stray ACTIVE appears in a cycle that should carry NOP, so the command pins differ at most RD_OFF cycles after the request is taken. A wrong spacing counter shows on req_ready in the cycle it should rise or stay low, and a back-to-back pair of requests exposes it as an early or late second ACTIVE. A wrong capture delay or column mask shows three cycles after READ. The word taken then no longer matches the word the memory model placed on the data bus for that bank, row and column.

// File: rtl/sdram_rdap_pkg.sv
package sdram_rdap_pkg;

  localparam int unsigned BA_W    = 2;
  localparam int unsigned ROW_W   = 12;
  localparam int unsigned COLIN_W = 10;
  localparam int unsigned AP_BIT  = 10;
  localparam int unsigned CAS_LAT = 2;

  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DRAIN
  } seq_st_e;

  typedef struct packed {
    logic [BA_W-1:0]    ba;
    logic [ROW_W-1:0]   row;
    logic [COLIN_W-1:0] col;
  } rd_req_t;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned col_bits(int unsigned dw);
    if (dw >= 16) return 8;
    else if (dw >= 8) return 9;
    else return 10;
  endfunction

  function automatic int unsigned read_offset(int unsigned rcd_c, int unsigned ras_c);
    return umax(umax(rcd_c, (ras_c > 0) ? ras_c - 1 : 0), 1);
  endfunction

endpackage

// File: rtl/rdap_timer.sv
module rdap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rdap_cmd_gen.sv
module rdap_cmd_gen
  import sdram_rdap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_act,
  input  logic               issue_rd,
  input  logic [BA_W-1:0]    act_ba,
  input  logic [ROW_W-1:0]   act_row,
  input  logic [BA_W-1:0]    rd_ba,
  input  logic [COLIN_W-1:0] rd_col,
  output logic [3:0]         cmd,
  output logic [BA_W-1:0]    ba,
  output logic [ROW_W-1:0]   addr
);
  localparam int unsigned COL_W = col_bits(DATA_W);

  logic [ROW_W-1:0] rd_addr;

  genvar i;
  generate
    for (i = 0; i < ROW_W; i++) begin : g_abit
      if (i == AP_BIT) begin : g_ap
        assign rd_addr[i] = 1'b1;
      end else if (i < COLIN_W) begin : g_col
        assign rd_addr[i] = rd_col[i] & ((i < COL_W) ? 1'b1 : 1'b0);
      end else begin : g_zero
        assign rd_addr[i] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else if (issue_act) begin
      cmd  <= CMD_ACT;
      ba   <= act_ba;
      addr <= act_row;
    end else if (issue_rd) begin
      cmd  <= CMD_RD;
      ba   <= rd_ba;
      addr <= rd_addr;
    end else begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end
  end
endmodule

// File: rtl/rdap_capture.sv
module rdap_capture
  import sdram_rdap_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CAS_LAT:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= rd_issue;
  end

  genvar k;
  generate
    for (k = 1; k <= CAS_LAT; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[k] <= 1'b0;
        else        pipe_q[k] <= pipe_q[k-1];
      end
    end
  endgenerate

  assign done = pipe_q[CAS_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= done;
      if (done) rd_data <= dq;
    end
  end
endmodule

// File: rtl/sdram_rdap_seq.sv
module sdram_rdap_seq
  import sdram_rdap_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RCD_NS = 20,
  parameter int unsigned T_RAS_NS = 44,
  parameter int unsigned T_RC_NS  = 66,
  parameter int unsigned T_RP_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_bank,
  input  logic [11:0]       req_row,
  input  logic [9:0]        req_col,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [11:0]       sd_addr,
  output logic              sd_dqm,
  input  logic [DATA_W-1:0] sd_dq
);
  localparam int unsigned RCD_C    = ns_to_cyc(T_RCD_NS, CLK_NS);
  localparam int unsigned RAS_C    = ns_to_cyc(T_RAS_NS, CLK_NS);
  localparam int unsigned RC_C     = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int unsigned RP_C     = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int unsigned RD_OFF   = read_offset(RCD_C, RAS_C);
  localparam int unsigned NEXT_ACT = umax(umax(RC_C, RD_OFF + 1 + RP_C), 1);
  localparam int unsigned OPEN_W   = $clog2(RD_OFF + 1) + 1;
  localparam int unsigned GAP_W    = $clog2(NEXT_ACT + 1) + 1;

  seq_st_e state_q, state_d;
  rd_req_t req_q;
  logic    accept, issue_rd, open_zero, gap_zero, cap_done;
  logic [3:0] cmd;

  assign req_ready = (state_q == ST_IDLE) && gap_zero;
  assign accept    = req_valid && req_ready;
  assign issue_rd  = (state_q == ST_OPEN) && open_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)   state_d = ST_OPEN;
      ST_OPEN:  if (issue_rd) state_d = ST_DRAIN;
      ST_DRAIN: if (cap_done) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) req_q <= '{ba: req_bank, row: req_row, col: req_col};
    end
  end

  rdap_timer #(.W(OPEN_W)) u_open_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (OPEN_W'(RD_OFF - 1)),
    .zero     (open_zero)
  );

  rdap_timer #(.W(GAP_W)) u_gap_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (GAP_W'(NEXT_ACT - 1)),
    .zero     (gap_zero)
  );

  rdap_cmd_gen #(.DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_act (accept),
    .issue_rd  (issue_rd),
    .act_ba    (req_bank),
    .act_row   (req_row),
    .rd_ba     (req_q.ba),
    .rd_col    (req_q.col),
    .cmd       (cmd),
    .ba        (sd_ba),
    .addr      (sd_addr)
  );

  rdap_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (issue_rd),
    .dq       (sd_dq),
    .done     (cap_done),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke = 1'b1;
  assign sd_dqm = 1'b0;
endmodule

// File: rtl/rdap_chk.sv
module rdap_chk
  import sdram_rdap_pkg::*;
#(
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned T_RCD_NS = 20,
  parameter int unsigned T_RAS_NS = 44,
  parameter int unsigned T_RC_NS  = 66,
  parameter int unsigned T_RP_NS  = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  cmd,
  input logic [1:0]  ba,
  input logic [11:0] addr,
  input logic        rd_valid
);
  localparam int unsigned RD_OFF = read_offset(ns_to_cyc(T_RCD_NS, CLK_NS),
                                               ns_to_cyc(T_RAS_NS, CLK_NS));
  localparam int unsigned NEXT_ACT = umax(umax(ns_to_cyc(T_RC_NS, CLK_NS),
                                          RD_OFF + 1 + ns_to_cyc(T_RP_NS, CLK_NS)), 1);

  logic [15:0] since_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_act <= 16'hFFFF;
    else if (cmd == CMD_ACT)      since_act <= 16'd1;
    else if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> cmd != CMD_ACT); // R2
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd == CMD_ACT); // R3
  AST_READ_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> since_act == 16'(RD_OFF)); // R4
  AST_A10_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> addr[AP_BIT]); // R5
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {CMD_NOP, CMD_ACT, CMD_RD}); // R6
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_RD |-> ##3 rd_valid); // R7
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_ACT |-> since_act >= 16'(NEXT_ACT)); // R8
  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_NOP |-> (addr == '0 && ba == '0)); // R9
endmodule

bind sdram_rdap_seq rdap_chk #(
  .CLK_NS   (CLK_NS),
  .T_RCD_NS (T_RCD_NS),
  .T_RAS_NS (T_RAS_NS),
  .T_RC_NS  (T_RC_NS),
  .T_RP_NS  (T_RP_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .ba        (sd_ba),
  .addr      (sd_addr),
  .rd_valid  (rd_valid)
);

// File: tb/sdram_rdap_seq_tb.sv
`timescale 1ns/1ps
module sdram_rdap_seq_tb;
  localparam int DW = 8;
  localparam int CLKNS = 10, RCD = 20, RAS = 44, RC = 90, RP = 20;
  localparam int RCD_C = (RCD + CLKNS - 1) / CLKNS;
  localparam int RAS_C = (RAS + CLKNS - 1) / CLKNS;
  localparam int RC_C  = (RC + CLKNS - 1) / CLKNS;
  localparam int RP_C  = (RP + CLKNS - 1) / CLKNS;
  localparam int E_RD  = (RCD_C > RAS_C - 1) ? RCD_C : RAS_C - 1;
  localparam int E_GAP = (RC_C > E_RD + 1 + RP_C) ? RC_C : E_RD + 1 + RP_C;
  localparam int E_RV  = E_RD + 3;
  localparam int E_RDY = (E_RV > E_GAP - 1) ? E_RV : E_GAP - 1;
  localparam logic [9:0] COLM = 10'h1FF;   // COL_W = 9 at width 8

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_bank = 0;
  logic [11:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
  logic [DW-1:0] rd_data, sd_dq = 0;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  always #2.5 clk = ~clk;

  sdram_rdap_seq #(.DATA_W(DW), .CLK_NS(CLKNS), .T_RCD_NS(RCD), .T_RAS_NS(RAS),
                   .T_RC_NS(RC), .T_RP_NS(RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq(sd_dq));

  int n_chk = 0, n_fail = 0, cyc = 0, ready_from = 1;
  string phase = "init";
  logic [3:0]    e_cmd [int];
  logic [11:0]   e_addr [int];
  logic [1:0]    e_ba [int];
  logic [DW-1:0] e_rd [int];
  logic [DW-1:0] dq_at [int];
  logic [11:0]   open_row [4];

  function automatic logic [DW-1:0] mem_word(logic [1:0] b, logic [11:0] r, logic [9:0] c);
    return DW'(int'(b) * 61 + int'(r) * 3 + int'(c) * 5 + 23);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] cyc=%0d %s got=%0h exp=%0h", req, phase, cyc, what, got, exp);
    end
  endtask

  task automatic check_cycle();
    logic [3:0] gc, ec;
    logic [11:0] ea;
    logic [1:0] eb;
    string tc, ta;
    gc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    ec = e_cmd.exists(cyc) ? e_cmd[cyc] : 4'b0111;
    ea = e_addr.exists(cyc) ? e_addr[cyc] : 12'h0;
    eb = e_ba.exists(cyc) ? e_ba[cyc] : 2'd0;
    if (ec == 4'b0011)      begin tc = "R3 R6"; ta = "R3"; end
    else if (ec == 4'b0101) begin tc = "R4 R6"; ta = "R5"; end
    else                    begin tc = "R8 R4"; ta = "R9"; end
    chk(tc, "cmd", 32'(gc), 32'(ec));
    chk(ta, "addr", 32'(sd_addr), 32'(ea));
    chk(ta, "ba", 32'(sd_ba), 32'(eb));
    chk("R2", "ready", 32'(req_ready), 32'(cyc >= ready_from));
    chk("R7", "rd_valid", 32'(rd_valid), 32'(e_rd.exists(cyc)));
    if (e_rd.exists(cyc)) chk("R7", "rd_data", 32'(rd_data), 32'(e_rd[cyc]));
    chk("R1", "cke", 32'(sd_cke), 32'd1);
    chk("R1", "dqm", 32'(sd_dqm), 32'd0);
  endtask

  task automatic sdram_model();
    logic [3:0] gc;
    gc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (gc == 4'b0011) open_row[sd_ba] = sd_addr;
    if (gc == 4'b0101)
      dq_at[cyc + 2] = mem_word(sd_ba, open_row[sd_ba], sd_addr[9:0] & COLM);
    sd_dq = dq_at.exists(cyc) ? dq_at[cyc] : DW'(cyc * 7 + 8'hC3);
  endtask

  task automatic step(input logic v, input logic [1:0] b, input logic [11:0] r,
                      input logic [9:0] c, output logic acc);
    int a;
    logic [9:0] cm;
    @(negedge clk);
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog cyc=%0d got=hung exp=done", cyc);
      finish_run();
    end
    check_cycle();
    sdram_model();
    req_valid = v; req_bank = b; req_row = r; req_col = c;
    acc = v && req_ready;
    if (acc) begin
      a = cyc + 1;
      cm = c & COLM;
      e_cmd[a] = 4'b0011; e_addr[a] = r; e_ba[a] = b;
      e_cmd[a + E_RD] = 4'b0101; e_addr[a + E_RD] = 12'h400 | 12'(cm); e_ba[a + E_RD] = b;
      e_rd[a + E_RV] = mem_word(b, r, cm);
      ready_from = a + E_RDY;
    end
  endtask

  task automatic idle(int n);
    logic acc;
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 12'd0, 10'd0, acc);
  endtask

  task automatic send(input logic [1:0] b, input logic [11:0] r, input logic [9:0] c);
    logic acc;
    acc = 0;
    while (!acc) step(1'b1, b, r, c, acc);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog time got=hung exp=done");
    finish_run();
  end

  initial begin
    logic acc;
    phase = "R1 reset";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
      chk("R1", "addr", 32'(sd_addr), 32'h0);
      chk("R1", "rd_valid", 32'(rd_valid), 32'h0);
      chk("R1", "cke", 32'(sd_cke), 32'h1);
      chk("R1", "dqm", 32'(sd_dqm), 32'h0);
    end
    rst_n = 1;
    idle(3);

    phase = "R3 single";
    send(2'd1, 12'h123, 10'h045);
    idle(14);

    phase = "R10 fields toggled while idle-valid low";
    send(2'd2, 12'hABC, 10'h0F0);
    for (int i = 0; i < 6; i++)
      step(1'b0, 2'(i), 12'(i * 291 + 7), 10'(i * 77), acc);
    idle(10);

    phase = "R8 back-to-back";
    send(2'd0, 12'h001, 10'h001);
    send(2'd3, 12'hFFF, 10'h1FE);
    send(2'd3, 12'h800, 10'h100);
    idle(14);

    phase = "R5 column mask";
    send(2'd1, 12'h555, 10'h3FF);
    send(2'd2, 12'h2AA, 10'h200);
    idle(14);

    phase = "R2 held valid";
    for (int b = 0; b < 4; b++) send(2'(b), 12'(b * 1000 + 5), 10'(b * 100 + 3));
    idle(16);
    finish_run();
  end
endmodule